// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block hands out and takes back numbered pages from a small pool of packet buffer pages for an Ethernet controller. It handles page numbers only. Frame bytes, buffer storage and CRC belong to other blocks. A register-side write port carries three kinds of write: a memory-management command byte, an interrupt acknowledge and an interrupt mask. The command opcode sits in the top three bits of the command byte. A separate packet-number operand names the page that a release or transmit-queue command acts on.

Internally the block keeps a page allocation bitmap and three shift queues: transmit, transmit completion and receive. Each queue is as deep as the page count. A receive source asks for pages with a request line. A transmit engine, enabled by a level input, sends queued pages one per cycle. A sent page is either freed at once or placed on the completion queue for software to reclaim. Four interrupt status bits feed a masked interrupt output: receive (bit 0), transmit done (bit 1), transmit queue empty (bit 2) and allocation done (bit 3).

A transmit allocation that finds no free page stays pending. It completes by itself on the next page release.

Top module: `pg_page_alloc`

## Requirements
- R1: After reset, used_count is 0, alloc_result is 0x00, done_head and rx_head both read 0x80, int_status is 0x04 and irq is 0.
- R2: A command write (wr_kind 0) with opcode 1 (wr_data[7:5] = 001) allocates the lowest-numbered free page. From the next cycle alloc_result shows that page number and status bit 3 is set.
- R3: An opcode 1 write on a full pool sets alloc_result to 0x80 and clears status bit 3. The request stays pending. The next release of any kind (opcode 5, opcode 4, or an automatic release after sending) gives the freed lowest page to it, writes that page to alloc_result and sets bit 3.
- R4: Opcode 5 frees the page named by pkt_num.
- R5: In a cycle with no write, rx_req is accepted (rx_accept high in that cycle) when a page is free and the receive queue has room. The lowest free page, shown on rx_page, is allocated and pushed onto the receive queue, and status bit 0 is set. Otherwise rx_accept stays low.
- R6: Opcode 3 pops the receive queue. Opcode 4 first frees the page at the queue head and then pops. After either one, bit 0 is 1 if entries remain and 0 if the queue is empty. Popping an empty queue changes nothing, and an empty queue reads 0x80.
- R7: Opcode 6 pushes pkt_num onto the transmit queue. While tx_enable is high and no write is present, the queue head is sent: tx_start is high and tx_page is the head in that cycle, one page per cycle in queue order. With auto_release high the page is freed. Otherwise it is pushed onto the completion queue, whose head appears on done_head. A push to any full queue is dropped.
- R8: An acknowledge write (wr_kind 1) clears the status bits selected by wr_data AND 0xD6, so bits 0 and 3 are never cleared this way. When wr_data bit 1 is set, the completion queue also pops one entry.
- R9: Status bit 2 is 1 in every cycle in which the transmit queue is empty. Status bit 1 is 1 in every cycle in which the completion queue holds an entry.
- R10: irq is 1 exactly when int_status AND the mask (set by a wr_kind 2 write) is non-zero, in the same cycle as the status.
- R11: Opcode 2 clears the bitmap, all three queues and the pending request, and sets alloc_result to 0x00. Opcode 7 empties the transmit and completion queues and leaves the pages allocated. Opcode 0 changes nothing.
- R12: used_count equals the number of allocated pages, from 0 to the page count.
- R13: While wr_en is high, rx_req is refused and no transmit is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register-side write strobe |
| wr_kind | input | 2 | 0 command, 1 acknowledge, 2 mask |
| wr_data | input | 8 | Command byte, acknowledge bits or mask value |
| pkt_num | input | PW | Packet-number operand for opcodes 5 and 6 |
| rx_req | input | 1 | Receive side asks for a page |
| tx_enable | input | 1 | Lets the transmit queue drain |
| auto_release | input | 1 | Free sent pages instead of queuing completion |
| rx_accept | output | 1 | Receive request granted this cycle |
| rx_page | output | PW | Page given to the receive side |
| tx_start | output | 1 | A page is sent this cycle |
| tx_page | output | PW | Page being sent |
| alloc_result | output | 8 | Last transmit allocation result, 0x80 when failed |
| done_head | output | 8 | Completion queue head, 0x80 when empty |
| rx_head | output | 8 | Receive queue head, 0x80 when empty |
| used_count | output | CW | Number of allocated pages |
| int_status | output | 8 | Interrupt status bits |
| irq | output | 1 | Masked interrupt request |

## Verification
Every write or background event is taken at one clock edge. alloc_result, the queue heads, used_count and int_status show the result from the following cycle, and irq follows int_status with no extra cycle. rx_accept, rx_page, tx_start and tx_page are combinational answers within the cycle in which the request is presented. The bench therefore drives inputs on the falling edge and reads the combinational answers shortly after driving. It reads registered results at the next falling edge, once the capturing rising edge has passed.

// File: rtl/pg_alloc_pkg.sv
`timescale 1ns/1ps
package pg_alloc_pkg;
   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_ALLOC   = 3'd1,
      OP_RESET   = 3'd2,
      OP_RXPOP   = 3'd3,
      OP_RXFREE  = 3'd4,
      OP_RELEASE = 3'd5,
      OP_TXQ     = 3'd6,
      OP_FLUSH   = 3'd7
   } mmu_op_e;

   typedef enum logic [1:0] {
      WK_CMD  = 2'd0,
      WK_ACK  = 2'd1,
      WK_MASK = 2'd2,
      WK_NONE = 2'd3
   } wr_kind_e;

   localparam int ST_RCV   = 0;
   localparam int ST_TX    = 1;
   localparam int ST_TXE   = 2;
   localparam int ST_ALLOC = 3;
   localparam int ST_BITS  = 4;

   localparam logic [7:0] ACK_CLEARABLE = 8'hD6;
   localparam logic [7:0] NONE_CODE     = 8'h80;
endpackage

// File: rtl/pg_shift_queue.sv
`timescale 1ns/1ps
module pg_shift_queue #(
   parameter int DEPTH = 4,
   parameter int W     = 2,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic [CW-1:0] count_next,
   output logic          empty,
   output logic          full
);
   localparam logic [CW-1:0] FULLC = CW'(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pg_shift_queue needs DEPTH >= 2");
      end
   endgenerate

   logic [W-1:0]  ent   [DEPTH];
   logic [W-1:0]  n_ent [DEPTH];
   logic [CW-1:0] cnt, n_cnt;

   always_comb begin
      n_ent = ent;
      n_cnt = cnt;
      if (clear) begin
         n_cnt = '0;
      end else begin
         if (pop && cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) n_ent[i] = ent[i+1];
            n_cnt = cnt - 1'b1;
         end
         if (push && n_cnt != FULLC) begin
            n_ent[n_cnt[IW-1:0]] = din;
            n_cnt = n_cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
      end else begin
         cnt <= n_cnt;
         ent <= n_ent;
      end
   end

   assign head       = ent[0];
   assign count      = cnt;
   assign count_next = n_cnt;
   assign empty      = (cnt == '0);
   assign full       = (cnt == FULLC);

   // R7: a push into a full queue with no pop is dropped
   assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clear) |=> (count == FULLC));

   assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULLC);
endmodule

// File: rtl/pg_page_pool.sv
`timescale 1ns/1ps
module pg_page_pool #(
   parameter int NPAGE = 4,
   localparam int PW   = $clog2(NPAGE),
   localparam int CW   = $clog2(NPAGE + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          rel_valid,
   input  logic [PW-1:0] rel_page,
   input  logic          want_a,
   input  logic          want_b,
   output logic          grant_a,
   output logic [PW-1:0] page_a,
   output logic          grant_b,
   output logic [PW-1:0] page_b,
   output logic [CW-1:0] used_count
);
   logic [NPAGE-1:0] bitmap, bm_rel, bm_a, bm_b;
   logic             free_a, free_b;

   always_comb begin
      bm_rel = bitmap;
      if (rel_valid) bm_rel[rel_page] = 1'b0;

      free_a = 1'b0;
      page_a = '0;
      for (int i = NPAGE - 1; i >= 0; i--) begin
         if (!bm_rel[i]) begin
            free_a = 1'b1;
            page_a = PW'(i);
         end
      end
      grant_a = want_a && free_a;
      bm_a = bm_rel;
      if (grant_a) bm_a[page_a] = 1'b1;

      free_b = 1'b0;
      page_b = '0;
      for (int i = NPAGE - 1; i >= 0; i--) begin
         if (!bm_a[i]) begin
            free_b = 1'b1;
            page_b = PW'(i);
         end
      end
      grant_b = want_b && free_b;
      bm_b = bm_a;
      if (grant_b) bm_b[page_b] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bitmap <= '0;
      else if (clear) bitmap <= '0;
      else            bitmap <= bm_b;
   end

   always_comb begin
      used_count = '0;
      for (int i = 0; i < NPAGE; i++) used_count = used_count + CW'(bitmap[i]);
   end

   // R2: a granted page is marked in use after the edge
   assert_grant_owned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_a && !clear) |=> bitmap[$past(page_a)]);

   // R5: a receive grant is marked in use after the edge
   assert_rx_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_b && !clear) |=> bitmap[$past(page_b)]);

   // R12: the count never exceeds the pool
   assert_count_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
      used_count <= CW'(NPAGE));
endmodule

// File: rtl/pg_page_alloc.sv
`timescale 1ns/1ps
module pg_page_alloc
   import pg_alloc_pkg::*;
#(
   parameter int NPAGE   = 4,
   parameter bit IRQ_REG = 1'b0,
   localparam int PW     = $clog2(NPAGE),
   localparam int CW     = $clog2(NPAGE + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_kind,
   input  logic [7:0]    wr_data,
   input  logic [PW-1:0] pkt_num,
   input  logic          rx_req,
   input  logic          tx_enable,
   input  logic          auto_release,
   output logic          rx_accept,
   output logic [PW-1:0] rx_page,
   output logic          tx_start,
   output logic [PW-1:0] tx_page,
   output logic [7:0]    alloc_result,
   output logic [7:0]    done_head,
   output logic [7:0]    rx_head,
   output logic [CW-1:0] used_count,
   output logic [7:0]    int_status,
   output logic          irq
);
   generate
      if (NPAGE < 2 || NPAGE > 64) begin : g_bad_pages
         $error("pg_page_alloc needs 2 <= NPAGE <= 64");
      end
   endgenerate

   function automatic logic [7:0] as_byte(input logic [PW-1:0] p);
      return {{(8-PW){1'b0}}, p};
   endfunction

   wr_kind_e kind;
   mmu_op_e  op;
   logic is_cmd, is_ack, is_mask;
   logic op_alloc, op_reset, op_rxpop, op_rxfree, op_release, op_txq, op_flush;

   assign kind       = wr_kind_e'(wr_kind);
   assign op         = mmu_op_e'(wr_data[7:5]);
   assign is_cmd     = wr_en && (kind == WK_CMD);
   assign is_ack     = wr_en && (kind == WK_ACK);
   assign is_mask    = wr_en && (kind == WK_MASK);
   assign op_alloc   = is_cmd && (op == OP_ALLOC);
   assign op_reset   = is_cmd && (op == OP_RESET);
   assign op_rxpop   = is_cmd && (op == OP_RXPOP);
   assign op_rxfree  = is_cmd && (op == OP_RXFREE);
   assign op_release = is_cmd && (op == OP_RELEASE);
   assign op_txq     = is_cmd && (op == OP_TXQ);
   assign op_flush   = is_cmd && (op == OP_FLUSH);

   logic [PW-1:0] txq_head, donq_head, rxq_head;
   logic [CW-1:0] txq_cnt, txq_nxt, donq_cnt, donq_nxt, rxq_cnt, rxq_nxt;
   logic          txq_empty, txq_full, donq_empty, donq_full, rxq_empty, rxq_full;

   logic          drain, rel_valid, want_a, want_b, grant_a, grant_b;
   logic [PW-1:0] rel_page, page_a, page_b;
   logic          pend_r, n_pend;
   logic [7:0]    res_r, n_res;
   logic [ST_BITS-1:0] st_r, n_st;
   logic [7:0]    mask_r;

   assign drain     = tx_enable && !wr_en && !txq_empty;
   assign rel_valid = op_release || (op_rxfree && !rxq_empty) || (drain && auto_release);
   assign rel_page  = op_release ? pkt_num : (op_rxfree ? rxq_head : txq_head);
   assign want_a    = op_alloc || (pend_r && rel_valid);
   assign want_b    = rx_req && !wr_en && !rxq_full;

   pg_page_pool #(.NPAGE(NPAGE)) i_pool (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (op_reset),
      .rel_valid  (rel_valid),
      .rel_page   (rel_page),
      .want_a     (want_a),
      .want_b     (want_b),
      .grant_a    (grant_a),
      .page_a     (page_a),
      .grant_b    (grant_b),
      .page_b     (page_b),
      .used_count (used_count)
   );

   pg_shift_queue #(.DEPTH(NPAGE), .W(PW)) i_txq (
      .clk(clk), .rst_n(rst_n),
      .clear(op_reset || op_flush),
      .push(op_txq), .din(pkt_num), .pop(drain),
      .head(txq_head), .count(txq_cnt), .count_next(txq_nxt),
      .empty(txq_empty), .full(txq_full)
   );

   pg_shift_queue #(.DEPTH(NPAGE), .W(PW)) i_donq (
      .clk(clk), .rst_n(rst_n),
      .clear(op_reset || op_flush),
      .push(drain && !auto_release), .din(txq_head), .pop(is_ack && wr_data[ST_TX]),
      .head(donq_head), .count(donq_cnt), .count_next(donq_nxt),
      .empty(donq_empty), .full(donq_full)
   );

   pg_shift_queue #(.DEPTH(NPAGE), .W(PW)) i_rxq (
      .clk(clk), .rst_n(rst_n),
      .clear(op_reset),
      .push(grant_b), .din(page_b), .pop(op_rxpop || op_rxfree),
      .head(rxq_head), .count(rxq_cnt), .count_next(rxq_nxt),
      .empty(rxq_empty), .full(rxq_full)
   );

   always_comb begin
      n_res  = res_r;
      n_pend = pend_r;
      if (op_reset) begin
         n_res  = 8'h00;
         n_pend = 1'b0;
      end else if (op_alloc) begin
         n_res  = grant_a ? as_byte(page_a) : NONE_CODE;
         n_pend = !grant_a;
      end else if (pend_r && grant_a) begin
         n_res  = as_byte(page_a);
         n_pend = 1'b0;
      end
   end

   always_comb begin
      n_st = st_r;
      if (op_alloc) n_st[ST_ALLOC] = 1'b0;
      if (grant_a)  n_st[ST_ALLOC] = 1'b1;
      if (is_ack)   n_st = n_st & ~wr_data[ST_BITS-1:0] & ~ACK_CLEARABLE[ST_BITS-1:0]
                           | n_st & ~wr_data[ST_BITS-1:0] & ACK_CLEARABLE[ST_BITS-1:0]
                           | n_st & ~ACK_CLEARABLE[ST_BITS-1:0];
      if (grant_b)  n_st[ST_RCV] = 1'b1;
      if (op_rxpop || op_rxfree) n_st[ST_RCV] = (rxq_nxt != '0);
      if (donq_nxt != '0) n_st[ST_TX]  = 1'b1;
      if (txq_nxt == '0)  n_st[ST_TXE] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_r  <= 8'h00;
         pend_r <= 1'b0;
         st_r   <= ST_BITS'(1 << ST_TXE);
         mask_r <= 8'h00;
      end else begin
         res_r  <= n_res;
         pend_r <= n_pend;
         st_r   <= n_st;
         if (is_mask) mask_r <= wr_data;
      end
   end

   assign int_status   = {{(8-ST_BITS){1'b0}}, st_r};
   assign alloc_result = res_r;
   assign done_head    = donq_empty ? NONE_CODE : as_byte(donq_head);
   assign rx_head      = rxq_empty  ? NONE_CODE : as_byte(rxq_head);
   assign rx_accept    = grant_b;
   assign rx_page      = page_b;
   assign tx_start     = drain;
   assign tx_page      = txq_head;

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |({{(8-ST_BITS){1'b0}}, n_st} & (is_mask ? wr_data : mask_r));
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = |(int_status & mask_r);
      end
   endgenerate

   // R9: transmit queue empty forces its status bit
   assert_txempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (txq_cnt == '0) |-> int_status[ST_TXE]);

   // R9: pending completions force the transmit-done bit
   assert_txdone_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (donq_cnt != '0) |-> int_status[ST_TX]);

   // R3: allocating on a full pool reports failure next cycle
   assert_full_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_alloc && used_count == CW'(NPAGE)) |=> (alloc_result == NONE_CODE));

   // R13: writes stall the receive side
   assert_rx_stall_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_req && wr_en) |-> !rx_accept);

   // R13: writes stall the transmit side
   assert_tx_stall_R13: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !tx_start);
endmodule

// File: tb/test_pg_page_alloc.sv
`timescale 1ns/1ps
module test_pg_page_alloc;
   localparam int PW = 2;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_kind = 2'd0;
   logic [7:0]    wr_data = 8'h00;
   logic [PW-1:0] pkt_num = '0;
   logic          rx_req = 1'b0;
   logic          tx_enable = 1'b0;
   logic          auto_release = 1'b0;
   logic          rx_accept, tx_start, irq;
   logic [PW-1:0] rx_page, tx_page;
   logic [7:0]    alloc_result, done_head, rx_head, int_status;
   logic [CW-1:0] used_count;

   int nchecks = 0;
   int nfail   = 0;

   always #2.5 clk = ~clk;

   pg_page_alloc #(.NPAGE(4)) i_pg_page_alloc (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_data(wr_data),
      .pkt_num(pkt_num), .rx_req(rx_req), .tx_enable(tx_enable), .auto_release(auto_release),
      .rx_accept(rx_accept), .rx_page(rx_page), .tx_start(tx_start), .tx_page(tx_page),
      .alloc_result(alloc_result), .done_head(done_head), .rx_head(rx_head),
      .used_count(used_count), .int_status(int_status), .irq(irq)
   );

   // {kind, data, pkt, expected result, expected used, expected status, expected irq}
   localparam logic [42:0] VEC [13] = '{
      {2'd0, 8'h20, 8'd0, 8'h00, 8'd1, 8'h0C, 1'b0},
      {2'd0, 8'h20, 8'd0, 8'h01, 8'd2, 8'h0C, 1'b0},
      {2'd0, 8'h20, 8'd0, 8'h02, 8'd3, 8'h0C, 1'b0},
      {2'd0, 8'h20, 8'd0, 8'h03, 8'd4, 8'h0C, 1'b0},
      {2'd0, 8'h20, 8'd0, 8'h80, 8'd4, 8'h04, 1'b0},
      {2'd0, 8'hA0, 8'd2, 8'h02, 8'd4, 8'h0C, 1'b0},
      {2'd0, 8'hA0, 8'd1, 8'h02, 8'd3, 8'h0C, 1'b0},
      {2'd0, 8'h20, 8'd0, 8'h01, 8'd4, 8'h0C, 1'b0},
      {2'd1, 8'hFF, 8'd0, 8'h01, 8'd4, 8'h0C, 1'b0},
      {2'd2, 8'h08, 8'd0, 8'h01, 8'd4, 8'h0C, 1'b1},
      {2'd0, 8'h40, 8'd0, 8'h00, 8'd0, 8'h0C, 1'b1},
      {2'd2, 8'h00, 8'd0, 8'h00, 8'd0, 8'h0C, 1'b0},
      {2'd0, 8'h00, 8'd0, 8'h00, 8'd0, 8'h0C, 1'b0}
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      nchecks++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] k, input logic [7:0] d, input logic [PW-1:0] p);
      @(negedge clk);
      wr_en = 1'b1; wr_kind = k; wr_data = d; pkt_num = p;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; rx_req = 1'b0; tx_enable = 1'b0; auto_release = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #500000;
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end

   initial begin
      do_reset();
      chk("R1", "used_count", int'(used_count), 0);
      chk("R1", "alloc_result", int'(alloc_result), 8'h00);
      chk("R1", "done_head", int'(done_head), 8'h80);
      chk("R1", "rx_head", int'(rx_head), 8'h80);
      chk("R1", "int_status", int'(int_status), 8'h04);
      chk("R1", "irq", int'(irq), 0);

      // table: R2 R3 R4 R8 R10 R11 R12
      for (int i = 0; i < 13; i++) begin
         wr(VEC[i][42:41], VEC[i][40:33], VEC[i][26:25]);
         chk("R2/R3/R4", $sformatf("vec%0d alloc_result", i), int'(alloc_result), int'(VEC[i][24:17]));
         chk("R12", $sformatf("vec%0d used_count", i), int'(used_count), int'(VEC[i][16:9]));
         chk("R8", $sformatf("vec%0d int_status", i), int'(int_status), int'(VEC[i][8:1]));
         chk("R10", $sformatf("vec%0d irq", i), int'(irq), int'(VEC[i][0]));
      end

      // receive path: R5 R6 R8 R10 R13
      do_reset();
      @(negedge clk);
      rx_req = 1'b1;
      for (int i = 0; i < 4; i++) begin
         #1;
         chk("R5", "rx_accept", int'(rx_accept), 1);
         chk("R5", "rx_page", int'(rx_page), i);
         @(negedge clk);
      end
      #1;
      chk("R5", "rx_accept when full", int'(rx_accept), 0);
      rx_req = 1'b0;
      chk("R5", "used_count", int'(used_count), 4);
      chk("R5", "rx_head", int'(rx_head), 0);
      chk("R5", "int_status", int'(int_status), 8'h05);
      wr(2'd1, 8'hFF, 2'd0);
      chk("R8", "rcv kept by ack", int'(int_status), 8'h05);
      wr(2'd2, 8'h01, 2'd0);
      chk("R10", "irq on rcv", int'(irq), 1);
      wr(2'd0, 8'h60, 2'd0);
      chk("R6", "rx_head after pop", int'(rx_head), 1);
      chk("R6", "used after pop", int'(used_count), 4);
      chk("R6", "rcv kept", int'(int_status), 8'h05);
      wr(2'd0, 8'h80, 2'd0);
      chk("R6", "rx_head after free", int'(rx_head), 2);
      chk("R6", "used after free", int'(used_count), 3);
      wr(2'd0, 8'h80, 2'd0);
      wr(2'd0, 8'h80, 2'd0);
      chk("R6", "rx_head empty", int'(rx_head), 8'h80);
      chk("R6", "used after frees", int'(used_count), 1);
      chk("R6", "rcv cleared", int'(int_status), 8'h04);
      chk("R10", "irq cleared", int'(irq), 0);
      wr(2'd0, 8'h60, 2'd0);
      chk("R6", "pop empty rx_head", int'(rx_head), 8'h80);
      chk("R6", "pop empty used", int'(used_count), 1);
      @(negedge clk);
      wr_en = 1'b1; wr_kind = 2'd2; wr_data = 8'h01; rx_req = 1'b1;
      #1;
      chk("R13", "rx refused during write", int'(rx_accept), 0);
      @(negedge clk);
      wr_en = 1'b0; rx_req = 1'b0;
      chk("R13", "used unchanged", int'(used_count), 1);

      // transmit path: R7 R8 R9
      do_reset();
      wr(2'd0, 8'h20, 2'd0);
      wr(2'd0, 8'h20, 2'd0);
      wr(2'd0, 8'hC0, 2'd0);
      wr(2'd0, 8'hC0, 2'd1);
      chk("R9", "sticky tx_empty", int'(int_status), 8'h0C);
      wr(2'd1, 8'h04, 2'd0);
      chk("R9", "tx_empty cleared while queued", int'(int_status), 8'h08);
      @(negedge clk);
      tx_enable = 1'b1;
      for (int i = 0; i < 2; i++) begin
         #1;
         chk("R7", "tx_start", int'(tx_start), 1);
         chk("R7", "tx_page order", int'(tx_page), i);
         @(negedge clk);
      end
      #1;
      chk("R7", "tx idle", int'(tx_start), 0);
      chk("R7", "done_head", int'(done_head), 0);
      chk("R9", "status after send", int'(int_status), 8'h0E);
      chk("R7", "used kept", int'(used_count), 2);
      wr(2'd1, 8'h02, 2'd0);
      chk("R8", "done pop head", int'(done_head), 1);
      chk("R9", "tx bit reforced", int'(int_status), 8'h0E);
      wr(2'd1, 8'h02, 2'd0);
      chk("R8", "done empty", int'(done_head), 8'h80);
      chk("R8", "tx bit cleared", int'(int_status), 8'h0C);

      // auto release: R7
      @(negedge clk);
      tx_enable = 1'b0; auto_release = 1'b1;
      wr(2'd0, 8'hC0, 2'd1);
      wr(2'd0, 8'hC0, 2'd0);
      @(negedge clk);
      tx_enable = 1'b1;
      #1;
      chk("R7", "auto send first", int'(tx_page), 1);
      @(negedge clk);
      #1;
      chk("R7", "auto send second", int'(tx_page), 0);
      @(negedge clk);
      #1;
      chk("R7", "auto freed", int'(used_count), 0);
      chk("R7", "no completion", int'(done_head), 8'h80);

      // pending allocation satisfied by auto release: R3
      tx_enable = 1'b0;
      for (int i = 0; i < 4; i++) wr(2'd0, 8'h20, 2'd0);
      wr(2'd0, 8'h20, 2'd0);
      chk("R3", "full alloc fails", int'(alloc_result), 8'h80);
      wr(2'd0, 8'hC0, 2'd2);
      @(negedge clk);
      tx_enable = 1'b1;
      @(negedge clk);
      tx_enable = 1'b0;
      #1;
      chk("R3", "pending gets page", int'(alloc_result), 2);
      chk("R3", "pool full again", int'(used_count), 4);
      chk("R3", "alloc bit set", int'(int_status[3]), 1);

      // flush: R11
      wr(2'd0, 8'hC0, 2'd1);
      wr(2'd0, 8'hE0, 2'd0);
      chk("R11", "flush keeps pages", int'(used_count), 4);
      @(negedge clk);
      tx_enable = 1'b1;
      #1;
      chk("R11", "flushed queue sends nothing", int'(tx_start), 0);
      @(negedge clk);
      tx_enable = 1'b0;

      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end
endmodule